// File: doc/BRIEF.md
# Storage Operand Effective Address Generator

This block forms the effective address of a memory operand once an instruction has been decoded and its register operands have been read. The decoder supplies the base and index register numbers with the data read for them, the displacement fields, the address of the current instruction and a halfword-relative immediate. It also supplies a form select and an addressing-mode select. The block adds the selected terms and truncates the sum to the active addressing width. On the clock edge that samples a strobe, it captures the result.

A base or index field of zero means that no register is named, so that term adds nothing to the sum. The single-register form is the exception: it reads its register field literally. The displacement is either a 12-bit unsigned value or a 20-bit signed value built from two separate instruction fields. The relative form is counted in halfwords. Instruction decoding, register-file access, operand lengths and address translation are all done outside this block.

Top module: `oag_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `valid_o` is 0 and `addr_o` is 0.
- R2: `valid_o` is 1 in the cycle right after a clock edge that sampled `strobe_i`=1, and 0 in every other cycle.
- R3: `addr_o` keeps its value across every clock edge that samples `strobe_i`=0, whatever the other inputs do.
- R4: Form 1 (`form_i`=2'd1) gives base + displacement. A base number of 0 adds zero instead of `base_data_i`.
- R5: Form 2 (`form_i`=2'd2) gives index + base + displacement. An index number of 0 adds zero, and so does a base number of 0.
- R6: When `long_disp_i`=0, the displacement is `disp_lo_i` zero-extended to 64 bits. `disp_hi_i` is ignored.
- R7: When `long_disp_i`=1, the displacement is the 20-bit value {`disp_hi_i`,`disp_lo_i`} with the high field above the low field, sign-extended from bit 19.
- R8: Form 0 (`form_i`=2'd0) gives `base_data_i` unchanged, even when `base_num_i` is 0. The displacement, index and immediate are ignored.
- R9: Form 3 (`form_i`=2'd3) gives `inst_addr_i` + 2 × sign-extended `rel_imm_i`. Bit 0 of the result therefore equals bit 0 of `inst_addr_i`.
- R10: The sum wraps modulo 2^64. `amode_i`=2'b00 keeps bits 23:0, `amode_i`=2'b01 keeps bits 30:0, and `amode_i`=2'b1x keeps all 64 bits. The bits that are not kept read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Operand fields valid, capture this cycle |
| form_i | input | 2 | Address form: 0 register, 1 base+disp, 2 index+base+disp, 3 relative |
| long_disp_i | input | 1 | 1 selects the 20-bit signed displacement |
| amode_i | input | 2 | Address width: 00 24-bit, 01 31-bit, 1x 64-bit |
| base_num_i | input | 4 | Base (or single) register number |
| base_data_i | input | 64 | Content of the base register |
| index_num_i | input | 4 | Index register number |
| index_data_i | input | 64 | Content of the index register |
| disp_lo_i | input | 12 | Low displacement field |
| disp_hi_i | input | 8 | High displacement field |
| inst_addr_i | input | 64 | Address of the current instruction |
| rel_imm_i | input | 32 | Signed halfword-relative immediate |
| valid_o | output | 1 | Result captured in the previous cycle |
| addr_o | output | 64 | Effective address, held until the next strobe |

## Verification
The bench targets these corner cases, and each one has a distinct failure:
- **Register number zero.** A design that read register 0 literally in the base or index position would add a nonzero term. A design that suppressed register 0 in the single-register form would return zero where data is expected.
- **Displacement extension.** Long displacements with bit 19 set must subtract from the base. A design that zero-extended them would overshoot by 2^20. A short displacement with a nonzero high field exposes a design that leaks that field into the sum.
- **Relative immediate.** Negative immediates and odd instruction addresses expose a missing or misplaced shift, and a missing sign extension.
- **Truncation.** Sums that carry across bit 24, bit 31 and bit 64 show whether each mode cuts at the right width.
- **Hold.** Idle cycles with random inputs show whether the result holds between strobes.

// File: rtl/oag_pkg.sv
package oag_pkg;

  typedef enum logic [1:0] {
    FORM_REG = 2'd0,
    FORM_BD  = 2'd1,
    FORM_XBD = 2'd2,
    FORM_REL = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    AM_24  = 2'd0,
    AM_31  = 2'd1,
    AM_64A = 2'd2,
    AM_64B = 2'd3
  } amode_e;

endpackage

// File: rtl/oag_disp_ext.sv
module oag_disp_ext #(
  parameter int ADDR_W     = 64,
  parameter int SDISP_W    = 12,
  parameter int LDISP_HI_W = 8
) (
  input  logic [SDISP_W-1:0]    lo_i,
  input  logic [LDISP_HI_W-1:0] hi_i,
  input  logic                  long_i,
  output logic [ADDR_W-1:0]     disp_o
);
  localparam int LDISP_W = SDISP_W + LDISP_HI_W;

  logic [ADDR_W-1:0] short_ext;
  logic [ADDR_W-1:0] long_ext;

  always_comb begin
    short_ext = {{(ADDR_W-SDISP_W){1'b0}}, lo_i};
    long_ext  = {{(ADDR_W-LDISP_W){hi_i[LDISP_HI_W-1]}}, hi_i, lo_i};
    disp_o    = long_i ? long_ext : short_ext;
  end
endmodule

// File: rtl/oag_reg_gate.sv
module oag_reg_gate #(
  parameter int ADDR_W    = 64,
  parameter int REG_NUM_W = 4
) (
  input  logic [REG_NUM_W-1:0] num_i,
  input  logic [ADDR_W-1:0]    data_i,
  input  logic                 literal_i,
  output logic [ADDR_W-1:0]    term_o
);
  logic named;

  always_comb begin
    named  = literal_i || (num_i != '0);
    term_o = named ? data_i : '0;
  end
endmodule

// File: rtl/oag_wrap.sv
module oag_wrap
  import oag_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int NARROW_W = 24,
  parameter int MID_W    = 31
) (
  input  logic [ADDR_W-1:0] sum_i,
  input  logic [1:0]        amode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] MASK_NARROW = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [ADDR_W-1:0] MASK_MID    = {{(ADDR_W-MID_W){1'b0}}, {MID_W{1'b1}}};

  logic [ADDR_W-1:0] mask;

  always_comb begin
    case (amode_e'(amode_i))
      AM_24:   mask = MASK_NARROW;
      AM_31:   mask = MASK_MID;
      default: mask = '1;
    endcase
    addr_o = sum_i & mask;
  end
endmodule

// File: rtl/oag_top.sv
module oag_top
  import oag_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int REG_NUM_W  = 4,
  parameter int SDISP_W    = 12,
  parameter int LDISP_HI_W = 8,
  parameter int IMM_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe_i,
  input  logic [1:0]            form_i,
  input  logic                  long_disp_i,
  input  logic [1:0]            amode_i,
  input  logic [REG_NUM_W-1:0]  base_num_i,
  input  logic [ADDR_W-1:0]     base_data_i,
  input  logic [REG_NUM_W-1:0]  index_num_i,
  input  logic [ADDR_W-1:0]     index_data_i,
  input  logic [SDISP_W-1:0]    disp_lo_i,
  input  logic [LDISP_HI_W-1:0] disp_hi_i,
  input  logic [ADDR_W-1:0]     inst_addr_i,
  input  logic [IMM_W-1:0]      rel_imm_i,
  output logic                  valid_o,
  output logic [ADDR_W-1:0]     addr_o
);
  localparam int NOPS = 2;

  form_e             form;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] rel_off;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] wrapped;

  logic [NOPS-1:0][REG_NUM_W-1:0] op_num;
  logic [NOPS-1:0][ADDR_W-1:0]    op_data;
  logic [NOPS-1:0]                op_lit;
  logic [NOPS-1:0][ADDR_W-1:0]    op_term;

  logic              valid_d, valid_q;
  logic [ADDR_W-1:0] addr_d,  addr_q;

  assign form = form_e'(form_i);

  oag_disp_ext #(
    .ADDR_W(ADDR_W), .SDISP_W(SDISP_W), .LDISP_HI_W(LDISP_HI_W)
  ) u_disp (
    .lo_i(disp_lo_i), .hi_i(disp_hi_i), .long_i(long_disp_i), .disp_o(disp)
  );

  // slot 0 is the base (or single) register, slot 1 the index register
  assign op_num[0]  = base_num_i;
  assign op_data[0] = base_data_i;
  assign op_lit[0]  = (form == FORM_REG);
  assign op_num[1]  = index_num_i;
  assign op_data[1] = index_data_i;
  assign op_lit[1]  = 1'b0;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    oag_reg_gate #(
      .ADDR_W(ADDR_W), .REG_NUM_W(REG_NUM_W)
    ) u_gate (
      .num_i(op_num[g]), .data_i(op_data[g]), .literal_i(op_lit[g]),
      .term_o(op_term[g])
    );
  end

  always_comb begin
    rel_off = {{(ADDR_W-IMM_W-1){rel_imm_i[IMM_W-1]}}, rel_imm_i, 1'b0};
    case (form)
      FORM_REG: sum = op_term[0];
      FORM_BD:  sum = op_term[0] + disp;
      FORM_XBD: sum = op_term[0] + op_term[1] + disp;
      default:  sum = inst_addr_i + rel_off;
    endcase
  end

  oag_wrap #(.ADDR_W(ADDR_W)) u_wrap (
    .sum_i(sum), .amode_i(amode_i), .addr_o(wrapped)
  );

  always_comb begin
    valid_d = strobe_i;
    addr_d  = addr_q;
    if (strobe_i) addr_d = wrapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;

  // R2
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == $past(strobe_i));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(addr_o));

  // R10
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && amode_i == 2'b00) |=> (addr_o[ADDR_W-1:24] == '0));

  // R10
  mid_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && amode_i == 2'b01) |=> (addr_o[ADDR_W-1:31] == '0));

  // R9
  rel_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && form_i == 2'd3) |=> (addr_o[0] == $past(inst_addr_i[0])));

  // R8
  single_reg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && form_i == 2'd0 && amode_i[1]) |=> (addr_o == $past(base_data_i)));
endmodule

// File: tb/oag_top_tb.sv
module oag_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe_i;
  logic [1:0]  form_i;
  logic        long_disp_i;
  logic [1:0]  amode_i;
  logic [3:0]  base_num_i, index_num_i;
  logic [63:0] base_data_i, index_data_i, inst_addr_i;
  logic [11:0] disp_lo_i;
  logic [7:0]  disp_hi_i;
  logic [31:0] rel_imm_i;
  logic        valid_o;
  logic [63:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  oag_top u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .form_i(form_i),
    .long_disp_i(long_disp_i), .amode_i(amode_i), .base_num_i(base_num_i),
    .base_data_i(base_data_i), .index_num_i(index_num_i),
    .index_data_i(index_data_i), .disp_lo_i(disp_lo_i), .disp_hi_i(disp_hi_i),
    .inst_addr_i(inst_addr_i), .rel_imm_i(rel_imm_i), .valid_o(valid_o),
    .addr_o(addr_o)
  );

  function automatic logic [63:0] expect_addr();
    logic [63:0] b, x, d, s;
    b = (base_num_i == 0) ? 64'd0 : base_data_i;
    x = (index_num_i == 0) ? 64'd0 : index_data_i;
    if (long_disp_i) d = 64'($signed({disp_hi_i, disp_lo_i}));
    else             d = {52'd0, disp_lo_i};
    case (form_i)
      2'd0:    s = base_data_i;
      2'd1:    s = b + d;
      2'd2:    s = b + x + d;
      default: s = inst_addr_i + (64'($signed(rel_imm_i)) << 1);
    endcase
    if (amode_i == 2'b00)      s = s & 64'h0000_0000_00FF_FFFF;
    else if (amode_i == 2'b01) s = s & 64'h0000_0000_7FFF_FFFF;
    return s;
  endfunction

  function automatic string form_tag(logic [1:0] f);
    case (f)
      2'd0:    return "R8";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic randomize_fields();
    form_i       = 2'($urandom);
    long_disp_i  = 1'($urandom);
    amode_i      = 2'($urandom);
    base_num_i   = ($urandom % 4 == 0) ? 4'd0 : 4'($urandom);
    index_num_i  = ($urandom % 4 == 0) ? 4'd0 : 4'($urandom);
    base_data_i  = {$urandom, $urandom};
    index_data_i = {$urandom, $urandom};
    disp_lo_i    = 12'($urandom);
    disp_hi_i    = 8'($urandom);
    inst_addr_i  = {$urandom, $urandom};
    rel_imm_i    = $urandom;
  endtask

  // drive at negedge with strobe, check at the following negedge
  task automatic issue(string tag);
    logic [63:0] exp;
    exp = expect_addr();
    strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
    check("R2", {63'd0, valid_o}, 64'd1);
    check(tag, addr_o, exp);
  endtask

  task automatic idle(int n);
    logic [63:0] held;
    held = addr_o;
    for (int i = 0; i < n; i++) begin
      randomize_fields();
      @(negedge clk);
      check("R2", {63'd0, valid_o}, 64'd0);
      check("R3", addr_o, held);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    strobe_i = 1'b0;
    randomize_fields();
    repeat (3) @(negedge clk);
    check("R1", {63'd0, valid_o}, 64'd0);
    check("R1", addr_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {63'd0, valid_o}, 64'd0);
    check("R1", addr_o, 64'd0);

    // R4: base number zero adds nothing
    randomize_fields();
    form_i = 2'd1; amode_i = 2'b10; long_disp_i = 1'b0;
    base_num_i = 4'd0; base_data_i = 64'hDEAD_BEEF_0000_1111; disp_lo_i = 12'h123;
    issue("R4");
    // R6: short displacement ignores high field, zero-extends
    form_i = 2'd1; base_num_i = 4'd5; base_data_i = 64'h1000;
    disp_lo_i = 12'hFFF; disp_hi_i = 8'hFF;
    issue("R6");
    // R7: negative long displacement
    long_disp_i = 1'b1; disp_hi_i = 8'h80; disp_lo_i = 12'h000;
    base_data_i = 64'h0000_0000_0010_0000;
    issue("R7");
    // R5: index zero, base nonzero
    form_i = 2'd2; long_disp_i = 1'b0; index_num_i = 4'd0;
    index_data_i = 64'hFFFF_FFFF_FFFF_FFFF; disp_lo_i = 12'h004;
    issue("R5");
    // R8: single register form reads register 0 literally
    form_i = 2'd0; base_num_i = 4'd0; base_data_i = 64'h8765_4321_0FED_CBA9;
    issue("R8");
    // R9: negative immediate, odd instruction address
    form_i = 2'd3; inst_addr_i = 64'h0000_0000_0000_1001; rel_imm_i = 32'hFFFF_FFFF;
    issue("R9");
    // R10: 64-bit wrap
    form_i = 2'd2; base_num_i = 4'd1; index_num_i = 4'd2;
    base_data_i = 64'hFFFF_FFFF_FFFF_FFF0; index_data_i = 64'h20; disp_lo_i = 12'h0;
    issue("R10");
    // R10: 31-bit and 24-bit truncation
    base_data_i = 64'h0000_0000_7FFF_FFF0; amode_i = 2'b01;
    issue("R10");
    base_data_i = 64'h0000_0000_00FF_FFF0; amode_i = 2'b00;
    issue("R10");
    idle(3);

    for (int n = 0; n < 400; n++) begin
      randomize_fields();
      issue(form_tag(form_i));
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule